// File: doc/BRIEF.md
# Calendar Real-Time Clock with Lockable Scratch RAM

The block keeps calendar time (second, minute, hour, day of month, month and a two-digit year) from a 32.768 kHz clock enable. A prescaler turns every `TICKS_PER_SEC` enabled ticks into one seconds step. A ripple state machine then advances the fields one at a time and ends with a compare slot for the alarm. The alarm can watch any mix of second, minute, hour, day and month, so a wake can be set for a time of day, for a date up to a month away, or for a day within the coming year. A match sets a sticky wake flag, which software clears.

The block also holds 256 bytes of general-purpose RAM on the same byte-wide register bus. Two windows of 8 bytes each can be sealed by a lock bit that only reset can clear. While a window is sealed, reads of it return 0xFF and writes to it are dropped.

The calendar state machine has the states ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DAY, ST_MON, ST_YEAR and ST_CHECK. Its transitions are as follows:
- ST_IDLE moves to ST_SEC on a seconds pulse.
- Each field state moves to the next field state when its field wraps, and to ST_CHECK when it does not.
- ST_YEAR always moves to ST_CHECK.
- ST_CHECK always returns to ST_IDLE.

Top module: `rtc_lockram`

## Requirements
- R1: After reset the time reads 00:00:00, day 1, month 1, year 0, the wake flag and both lock bits are 0, and the alarm fields and mask are 0. Reset does not clear the RAM contents.
- R2: The seconds field advances by one after every `TICKS_PER_SEC` cycles in which `tick_en` is high (default 32768). It does not advance while `tick_en` is low. Any write to a time register restarts the prescaler from zero.
- R3: The fields wrap as follows: second 59 to 0, minute 59 to 0, hour 23 to 0, month 12 to 1, year 99 to 0. Each wrap carries one into the next field.
- R4: The day wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months except February. February ends at day 29 when the year is divisible by 4, and at day 28 otherwise.
- R5: The alarm mask register has bit0 for second, bit1 for minute, bit2 for hour, bit3 for day and bit4 for month. After every seconds step the wake flag sets when each enabled alarm field equals the new time field. Disabled fields are ignored, so a mask of 0 matches on every step.
- R6: The wake flag is status bit0 and also drives the `wake` port. It stays set until software writes a 1 to status bit0. If a new match and a clear fall in the same cycle, the match wins.
- R7: The register map is 0x000 second, 0x001 minute, 0x002 hour, 0x003 day, 0x004 month, 0x005 year, 0x008 to 0x00C alarm second, minute, hour, day and month, 0x00D alarm mask, 0x00E status and 0x00F lock. RAM byte n sits at 0x100+n. Read data appears on `bus_rdata` one clock after the read request and holds until the next read.
- R8: Lock bit0 seals RAM bytes `WIN_A_BASE` to `WIN_A_BASE`+7 (default 0x20), and lock bit1 seals `WIN_B_BASE` to `WIN_B_BASE`+7 (default 0xF8). Writing a 1 sets a bit. Writing a 0 has no effect, so only reset clears a lock bit.
- R9: A read of a sealed byte returns 0xFF. A write to a sealed byte leaves it unchanged. Bytes outside a sealed window stay fully accessible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| bus_sel | input | 1 | Register bus request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 9 | Byte address (bit 8 selects RAM) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the request |
| wake | output | 1 | Sticky alarm wake flag |

## Verification
Date-dependent behaviour is the hardest part to reach from the ports: the February and leap-year ends, the year wrap, and alarms keyed to day and month. At the real tick rate each would lie days or months of simulated time away. The bench shrinks the prescaler through its parameter, writes a time one second before each boundary, and then runs exactly one second of enabled ticks. The lock rule that a dropped write leaves the byte unchanged cannot be seen while the window stays sealed. The bench therefore attempts the write, applies a reset (which keeps the RAM but opens the lock), and reads the original byte back.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DAY,
        ST_MON,
        ST_YEAR,
        ST_CHECK
    } cal_state_t;

    localparam int NUM_ALARM_FIELDS = 5;

    function automatic logic [7:0] days_in_month(input logic [7:0] mon, input logic [7:0] year);
        logic [7:0] len;
        case (mon)
            8'd2:                       len = (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:    len = 8'd30;
            default:                    len = 8'd31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic clear,
    output logic sec_pulse
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;

    assign sec_pulse = tick_en && !clear && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_pulse,
    input  logic       wr_en,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    output rtc_time_t  now,
    output logic       check_pulse
);
    cal_state_t state_q, state_d;
    rtc_time_t  t_q;
    logic [7:0] month_len;

    assign month_len   = days_in_month(t_q.mon, t_q.year);
    assign now         = t_q;
    assign check_pulse = (state_q == ST_CHECK);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = sec_pulse ? ST_SEC : ST_IDLE;
            ST_SEC:   state_d = (t_q.sec  >= 8'd59)    ? ST_MIN  : ST_CHECK;
            ST_MIN:   state_d = (t_q.min  >= 8'd59)    ? ST_HOUR : ST_CHECK;
            ST_HOUR:  state_d = (t_q.hour >= 8'd23)    ? ST_DAY  : ST_CHECK;
            ST_DAY:   state_d = (t_q.day  >= month_len) ? ST_MON : ST_CHECK;
            ST_MON:   state_d = (t_q.mon  >= 8'd12)    ? ST_YEAR : ST_CHECK;
            ST_YEAR:  state_d = ST_CHECK;
            ST_CHECK: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{year: 8'd0, mon: 8'd1, day: 8'd1, hour: 8'd0, min: 8'd0, sec: 8'd0};
        end else if (wr_en) begin
            case (wr_idx)
                3'd0:    t_q.sec  <= wr_data;
                3'd1:    t_q.min  <= wr_data;
                3'd2:    t_q.hour <= wr_data;
                3'd3:    t_q.day  <= wr_data;
                3'd4:    t_q.mon  <= wr_data;
                3'd5:    t_q.year <= wr_data;
                default: ;
            endcase
        end else begin
            unique case (state_q)
                ST_SEC:  t_q.sec  <= (t_q.sec  >= 8'd59)     ? 8'd0 : t_q.sec  + 8'd1;
                ST_MIN:  t_q.min  <= (t_q.min  >= 8'd59)     ? 8'd0 : t_q.min  + 8'd1;
                ST_HOUR: t_q.hour <= (t_q.hour >= 8'd23)     ? 8'd0 : t_q.hour + 8'd1;
                ST_DAY:  t_q.day  <= (t_q.day  >= month_len) ? 8'd1 : t_q.day  + 8'd1;
                ST_MON:  t_q.mon  <= (t_q.mon  >= 8'd12)     ? 8'd1 : t_q.mon  + 8'd1;
                ST_YEAR: t_q.year <= (t_q.year >= 8'd99)     ? 8'd0 : t_q.year + 8'd1;
                ST_IDLE, ST_CHECK: ;
            endcase
        end
    end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_ALARM_FIELDS-1:0][7:0]  cur,
    input  logic                              check,
    input  logic                              wr_en,
    input  logic [2:0]                        wr_idx,
    input  logic [7:0]                        wr_data,
    input  logic                              clr,
    input  logic [2:0]                        rd_idx,
    output logic [7:0]                        rd_data,
    output logic                              hit,
    output logic                              wake
);
    logic [NUM_ALARM_FIELDS-1:0][7:0] alm_q;
    logic [NUM_ALARM_FIELDS-1:0]      mask_q;
    logic [NUM_ALARM_FIELDS-1:0]      field_ok;

    for (genvar i = 0; i < NUM_ALARM_FIELDS; i++) begin : g_cmp
        assign field_ok[i] = !mask_q[i] || (cur[i] == alm_q[i]);
    end

    assign hit = check && (&field_ok);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_idx == 3'd5) mask_q <= wr_data[NUM_ALARM_FIELDS-1:0];
            else                alm_q[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   wake <= 1'b0;
        else if (hit) wake <= 1'b1;
        else if (clr) wake <= 1'b0;
    end

    always_comb begin
        case (rd_idx)
            3'd0, 3'd1, 3'd2, 3'd3, 3'd4: rd_data = alm_q[rd_idx];
            3'd5:    rd_data = {{(8-NUM_ALARM_FIELDS){1'b0}}, mask_q};
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
    parameter logic [7:0] WIN_A_BASE = 8'h20,
    parameter logic [7:0] WIN_B_BASE = 8'hF8,
    parameter int         WIN_BYTES  = 8,
    parameter int         DEPTH      = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wr_data,
    input  logic       lock_wr,
    input  logic [1:0] lock_bits,
    output logic [7:0] rd_data,
    output logic [1:0] lock_q
);
    logic [7:0] mem [DEPTH];
    logic [1:0] in_win;
    logic       sealed;

    for (genvar w = 0; w < 2; w++) begin : g_win
        localparam logic [7:0] BASE = (w == 0) ? WIN_A_BASE : WIN_B_BASE;
        logic [7:0] off;
        assign off       = addr - BASE;
        assign in_win[w] = (addr >= BASE) && (off < 8'(WIN_BYTES));
    end

    assign sealed  = |(in_win & lock_q);
    assign rd_data = sealed ? 8'hFF : mem[addr];

    always_ff @(posedge clk) begin
        if (wr_en && !sealed) mem[addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= 2'b00;
        else if (lock_wr) lock_q <= lock_q | lock_bits;
    end
endmodule

// File: rtl/rtc_lockram.sv
module rtc_lockram
    import rtc_pkg::*;
#(
    parameter int         TICKS_PER_SEC = 32768,
    parameter logic [7:0] WIN_A_BASE    = 8'h20,
    parameter logic [7:0] WIN_B_BASE    = 8'hF8,
    parameter int         WIN_BYTES     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [8:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wake
);
    logic       is_ram, is_low, is_time, is_alarm, is_status, is_lock;
    logic       wr_cyc, rd_cyc;
    logic       time_wr, alarm_wr, status_clr, lock_wr;
    logic       sec_pulse, check_pulse, alarm_hit;
    logic [7:0] alarm_rd, ram_rd, rd_mux, rdata_q;
    logic [1:0] lock_q;
    rtc_time_t  now;

    assign wr_cyc    = bus_sel && bus_wr;
    assign rd_cyc    = bus_sel && !bus_wr;
    assign is_ram    = bus_addr[8];
    assign is_low    = (bus_addr[8:4] == 5'd0);
    assign is_time   = is_low && !bus_addr[3] && (bus_addr[2:0] < 3'd6);
    assign is_alarm  = is_low && bus_addr[3] && (bus_addr[2:0] < 3'd6);
    assign is_status = is_low && (bus_addr[3:0] == 4'hE);
    assign is_lock   = is_low && (bus_addr[3:0] == 4'hF);

    assign time_wr    = wr_cyc && is_time;
    assign alarm_wr   = wr_cyc && is_alarm;
    assign status_clr = wr_cyc && is_status && bus_wdata[0];
    assign lock_wr    = wr_cyc && is_lock;

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .clear     (time_wr),
        .sec_pulse (sec_pulse)
    );

    rtc_calendar u_cal (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_pulse   (sec_pulse),
        .wr_en       (time_wr),
        .wr_idx      (bus_addr[2:0]),
        .wr_data     (bus_wdata),
        .now         (now),
        .check_pulse (check_pulse)
    );

    rtc_alarm u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     ({now.mon, now.day, now.hour, now.min, now.sec}),
        .check   (check_pulse),
        .wr_en   (alarm_wr),
        .wr_idx  (bus_addr[2:0]),
        .wr_data (bus_wdata),
        .clr     (status_clr),
        .rd_idx  (bus_addr[2:0]),
        .rd_data (alarm_rd),
        .hit     (alarm_hit),
        .wake    (wake)
    );

    rtc_ram #(
        .WIN_A_BASE (WIN_A_BASE),
        .WIN_B_BASE (WIN_B_BASE),
        .WIN_BYTES  (WIN_BYTES)
    ) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_cyc && is_ram),
        .addr      (bus_addr[7:0]),
        .wr_data   (bus_wdata),
        .lock_wr   (lock_wr),
        .lock_bits (bus_wdata[1:0]),
        .rd_data   (ram_rd),
        .lock_q    (lock_q)
    );

    always_comb begin
        rd_mux = 8'h00;
        if (is_ram) begin
            rd_mux = ram_rd;
        end else if (is_time) begin
            case (bus_addr[2:0])
                3'd0:    rd_mux = now.sec;
                3'd1:    rd_mux = now.min;
                3'd2:    rd_mux = now.hour;
                3'd3:    rd_mux = now.day;
                3'd4:    rd_mux = now.mon;
                default: rd_mux = now.year;
            endcase
        end else if (is_alarm) begin
            rd_mux = alarm_rd;
        end else if (is_status) begin
            rd_mux = {7'd0, wake};
        end else if (is_lock) begin
            rd_mux = {6'd0, lock_q};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= 8'h00;
        else if (rd_cyc) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/rtc_lockram_chk.sv
module rtc_lockram_chk #(
    parameter logic [7:0] WIN_A_BASE = 8'h20,
    parameter logic [7:0] WIN_B_BASE = 8'hF8,
    parameter int         WIN_BYTES  = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [8:0] bus_addr,
    input logic       clr_bit,
    input logic [7:0] bus_rdata,
    input logic       wake,
    input logic [1:0] lock_q,
    input logic       alarm_hit
);
    logic [7:0] off_a, off_b;
    logic       sealed_rd, clr_req;

    assign off_a     = bus_addr[7:0] - WIN_A_BASE;
    assign off_b     = bus_addr[7:0] - WIN_B_BASE;
    assign sealed_rd = bus_sel && !bus_wr && bus_addr[8] &&
                       ((lock_q[0] && bus_addr[7:0] >= WIN_A_BASE && off_a < 8'(WIN_BYTES)) ||
                        (lock_q[1] && bus_addr[7:0] >= WIN_B_BASE && off_b < 8'(WIN_BYTES)));
    assign clr_req   = bus_sel && bus_wr && (bus_addr == 9'h00E) && clr_bit;

    AST_LOCK_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[0] |=> lock_q[0]);  // R8
    AST_LOCK_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[1] |=> lock_q[1]);  // R8
    AST_SEALED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        sealed_rd |=> (bus_rdata == 8'hFF));  // R9
    AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !clr_req) |=> wake);  // R6
    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !alarm_hit) |=> !wake);  // R6
    AST_WAKE_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(alarm_hit));  // R5
endmodule

bind rtc_lockram rtc_lockram_chk #(
    .WIN_A_BASE (WIN_A_BASE),
    .WIN_B_BASE (WIN_B_BASE),
    .WIN_BYTES  (WIN_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .clr_bit   (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .wake      (wake),
    .lock_q    (lock_q),
    .alarm_hit (alarm_hit)
);

// File: tb/rtc_lockram_test.sv
`timescale 1ns/1ps
module rtc_lockram_test;
    localparam int TPS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [8:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rtc_lockram #(.TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake(wake)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [8:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
        wr(9'h005, y); wr(9'h004, mo); wr(9'h003, d);
        wr(9'h002, h); wr(9'h001, mi); wr(9'h000, s);
    endtask

    task automatic run_seconds(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n * TPS) @(negedge clk);
        tick_en = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic chk_time(input string tag, input logic [7:0] y, mo, d, h, mi, s);
        rd_chk({tag, " sec"},  9'h000, s);
        rd_chk({tag, " min"},  9'h001, mi);
        rd_chk({tag, " hour"}, 9'h002, h);
        rd_chk({tag, " day"},  9'h003, d);
        rd_chk({tag, " mon"},  9'h004, mo);
        rd_chk({tag, " year"}, 9'h005, y);
    endtask

    task automatic t_reset_state();
        chk_time("R1 reset", 8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0);
        rd_chk("R1 status", 9'h00E, 8'h00);
        rd_chk("R1 lock", 9'h00F, 8'h00);
        rd_chk("R1 mask", 9'h00D, 8'h00);
        chk("R1 wake port", {7'd0, wake}, 8'h00);
    endtask

    task automatic t_prescaler();
        repeat (5 * TPS) @(negedge clk);
        rd_chk("R2 no tick no advance", 9'h000, 8'd0);
        set_time(8'd10, 8'd3, 8'd3, 8'd1, 8'd2, 8'd7);
        run_seconds(3);
        rd_chk("R2 three seconds", 9'h000, 8'd10);
        @(negedge clk); tick_en = 1'b1;
        repeat (TPS - 2) @(negedge clk);
        tick_en = 1'b0;
        wr(9'h000, 8'd20);
        run_seconds(1);
        rd_chk("R2 write restarts prescaler", 9'h000, 8'd21);
    endtask

    task automatic t_rollovers();
        set_time(8'd5, 8'd6, 8'd15, 8'd23, 8'd59, 8'd58);
        run_seconds(2);
        chk_time("R3 midnight", 8'd5, 8'd6, 8'd16, 8'd0, 8'd0, 8'd0);
        set_time(8'd99, 8'd12, 8'd31, 8'd23, 8'd59, 8'd59);
        run_seconds(1);
        chk_time("R3 year wrap", 8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0);
    endtask

    task automatic t_month_lengths();
        set_time(8'd7, 8'd4, 8'd30, 8'd23, 8'd59, 8'd59);
        run_seconds(1);
        rd_chk("R4 30-day month day", 9'h003, 8'd1);
        rd_chk("R4 30-day month mon", 9'h004, 8'd5);
        set_time(8'd7, 8'd5, 8'd30, 8'd23, 8'd59, 8'd59);
        run_seconds(1);
        rd_chk("R4 31-day month day", 9'h003, 8'd31);
        set_time(8'd24, 8'd2, 8'd28, 8'd23, 8'd59, 8'd59);
        run_seconds(1);
        rd_chk("R4 leap feb 29", 9'h003, 8'd29);
        rd_chk("R4 leap feb mon", 9'h004, 8'd2);
        run_seconds(86400 / 86400);
        set_time(8'd24, 8'd2, 8'd29, 8'd23, 8'd59, 8'd59);
        run_seconds(1);
        rd_chk("R4 leap feb end day", 9'h003, 8'd1);
        rd_chk("R4 leap feb end mon", 9'h004, 8'd3);
        set_time(8'd23, 8'd2, 8'd28, 8'd23, 8'd59, 8'd59);
        run_seconds(1);
        rd_chk("R4 plain feb end day", 9'h003, 8'd1);
        rd_chk("R4 plain feb end mon", 9'h004, 8'd3);
    endtask

    task automatic t_alarm_time();
        wr(9'h00D, 8'h07);
        wr(9'h008, 8'd5); wr(9'h009, 8'd0); wr(9'h00A, 8'd10);
        set_time(8'd1, 8'd9, 8'd9, 8'd10, 8'd0, 8'd3);
        wr(9'h00E, 8'h01);
        rd_chk("R6 clear before test", 9'h00E, 8'h00);
        run_seconds(1);
        rd_chk("R5 no match yet", 9'h00E, 8'h00);
        run_seconds(1);
        rd_chk("R5 time match sets wake", 9'h00E, 8'h01);
        chk("R6 wake port", {7'd0, wake}, 8'h01);
        run_seconds(1);
        rd_chk("R6 wake sticky", 9'h00E, 8'h01);
        wr(9'h00E, 8'h00);
        rd_chk("R6 write 0 keeps wake", 9'h00E, 8'h01);
        wr(9'h00E, 8'h01);
        rd_chk("R6 write 1 clears", 9'h00E, 8'h00);
        chk("R6 wake port cleared", {7'd0, wake}, 8'h00);
    endtask

    task automatic t_alarm_date();
        wr(9'h00D, 8'h1F);
        wr(9'h008, 8'd0); wr(9'h009, 8'd0); wr(9'h00A, 8'd8);
        wr(9'h00B, 8'd3); wr(9'h00C, 8'd7);
        set_time(8'd21, 8'd7, 8'd4, 8'd7, 8'd59, 8'd59);
        wr(9'h00E, 8'h01);
        run_seconds(1);
        rd_chk("R5 day mismatch", 9'h00E, 8'h00);
        set_time(8'd21, 8'd8, 8'd3, 8'd7, 8'd59, 8'd59);
        run_seconds(1);
        rd_chk("R5 month mismatch", 9'h00E, 8'h00);
        set_time(8'd21, 8'd7, 8'd3, 8'd7, 8'd59, 8'd59);
        run_seconds(1);
        rd_chk("R5 date match", 9'h00E, 8'h01);
        wr(9'h00D, 8'h00);
        wr(9'h00E, 8'h01);
        run_seconds(1);
        rd_chk("R5 empty mask matches", 9'h00E, 8'h01);
        rd_chk("R7 alarm hour readback", 9'h00A, 8'd8);
    endtask

    task automatic t_ram_locks();
        wr(9'h110, 8'h3C);
        wr(9'h180, 8'hC3);
        rd_chk("R7 ram 0x10", 9'h110, 8'h3C);
        rd_chk("R7 ram 0x80", 9'h180, 8'hC3);
        for (int i = 0; i < 8; i++) wr(9'h120 + 9'(i), 8'hA0 + 8'(i));
        wr(9'h11F, 8'h5A);
        wr(9'h128, 8'h6B);
        wr(9'h1F8, 8'h77);
        wr(9'h00F, 8'h01);
        rd_chk("R8 lock A bit", 9'h00F, 8'h01);
        rd_chk("R9 sealed first", 9'h120, 8'hFF);
        rd_chk("R9 sealed last", 9'h127, 8'hFF);
        rd_chk("R9 below window", 9'h11F, 8'h5A);
        rd_chk("R9 above window", 9'h128, 8'h6B);
        rd_chk("R8 window B still open", 9'h1F8, 8'h77);
        wr(9'h123, 8'h55);
        wr(9'h00F, 8'h00);
        rd_chk("R8 write 0 keeps lock", 9'h00F, 8'h01);
        wr(9'h00F, 8'h02);
        rd_chk("R8 both locks", 9'h00F, 8'h03);
        rd_chk("R9 window B sealed", 9'h1F8, 8'hFF);
        do_reset();
        rd_chk("R8 reset clears lock", 9'h00F, 8'h00);
        rd_chk("R9 sealed write dropped", 9'h123, 8'hA3);
        rd_chk("R1 ram kept over reset", 9'h110, 8'h3C);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_prescaler();
        t_rollovers();
        t_month_lengths();
        t_alarm_time();
        t_alarm_date();
        t_ram_locks();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule